// File: doc/BRIEF.md
# LCD Multiplex Scan Driver with Display Memory

This block keeps a 34-word by 4-bit display memory and scans it without pause onto a 1/4-duty, 1/2-bias LCD with four common lines and thirty-four segment lines, 136 picture elements in all. A processor writes and reads the memory through a 4-bit data port. The address is a high nibble page and a low nibble word, matching the processor's data memory map. Each output line carries a 2-bit level code. An external bias network turns these codes into ground, half-supply or full-supply voltages.

The scan is an eight-state machine: S_H0_POS, S_H0_NEG, S_H1_POS, S_H1_NEG, S_H2_POS, S_H2_NEG, S_H3_POS, S_H3_NEG. Each `tick` pulse takes the transition to the next state in that list, and S_H3_NEG wraps back to S_H0_POS. Without a tick, the state holds. A common phase is two states of opposite polarity, so every element sees zero net DC over a full frame. The `blank` input puts every line at the half level while the scan keeps running.

Top module: `lcd_mux_drv`

## Requirements
- R1: After reset the scan is in S_H0_POS and every display word is zero. So com_lvl shows H0 at full level and H1..H3 at half level, and every segment is at full level.
- R2: Each clock with `tick` high advances the state one step in the order H0+, H0-, H1+, H1-, H2+, H2-, H3+, H3-, then back to H0+. A clock without `tick` keeps the state.
- R3: Level codes are 0 = ground, 1 = half supply, 2 = full supply. Line i occupies bits [2i+1:2i] of its output vector. When not blanked, the active common is at 2 in a positive half-phase and at 0 in a negative half-phase, and every other common is at 1.
- R4: When not blanked, a segment whose selected bit is 1 drives the level opposite to the active common (0 against 2, 2 against 0). A segment whose selected bit is 0 drives the same level as the active common.
- R5: Page 8, word k (k = 0..15) is the display word for segment 2k.
- R6: Page 9, word k (k = 0..15) is the display word for segment 2k+1.
- R7: Page 10, word 0 is the display word for segment 32, and page 11, word 0 is the display word for segment 33.
- R8: Bit i of a display word controls the element on common line i, and takes effect only while common i is active.
- R9: A write to an address that maps to no segment changes no display word, and a read from such an address returns 0.
- R10: A read of a mapped address returns, in the same cycle, the last value written there. This holds while the scan runs.
- R11: While `blank` is high, every common and segment code is 1. The scan state still advances on `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Half-phase advance enable |
| blank | input | 1 | Force every line to the half level |
| wr_en | input | 1 | Write strobe for the display memory |
| addr_hi | input | 4 | Page nibble of the memory address |
| addr_lo | input | 4 | Word nibble of the memory address |
| wr_data | input | 4 | Write data |
| rd_data | output | 4 | Read data for the current address (combinational) |
| com_lvl | output | 8 | Level codes for the four common lines |
| seg_lvl | output | 68 | Level codes for the 34 segment lines |

## Verification
On every clock, the assertions check the following. The state holds without a tick, and H3- wraps to H0+. When not blanked, exactly one common leaves the half level and no segment sits at the half level. Blanking puts every line at the half level. A write to an unmapped address leaves the whole display memory unchanged, and a mapped write lands in the addressed word. Only the bench scenarios can show the rest: the interleaved page-to-segment mapping, the choice of bit by the active common, the polarity of each segment against the common, and the readback values. For these, the bench compares the full output vectors against a model of the memory and the scan position.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int LCD_NCOM = 4;
    localparam int LCD_NPH  = 2 * LCD_NCOM;

    typedef enum logic [1:0] {
        LVL_GND  = 2'd0,
        LVL_HALF = 2'd1,
        LVL_FULL = 2'd2
    } lvl_e;

    // level seen on the opposite rail of the 1/2-bias ladder
    function automatic lvl_e lvl_mirror(input lvl_e l);
        return (l == LVL_FULL) ? LVL_GND : LVL_FULL;
    endfunction

endpackage

// File: rtl/lcd_disp_mem.sv
module lcd_disp_mem #(
    parameter int NSEG      = 34,
    parameter int DW        = 4,
    parameter int AW        = 4,
    parameter int PAGE_BASE = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr_hi,
    input  logic [AW-1:0]        addr_lo,
    input  logic [DW-1:0]        wr_data,
    output logic [DW-1:0]        rd_data,
    output logic [NSEG*DW-1:0]   words_flat
);
    localparam int PAIR_SEGS = 2 * (1 << AW);
    localparam int EXTRA     = NSEG - PAIR_SEGS;
    localparam int IW        = $clog2(NSEG);

    logic [DW-1:0] mem [NSEG];
    logic          hit;
    logic [IW-1:0] idx;

    // address decode: even page, odd page, then one-word pages
    always_comb begin
        hit = 1'b0;
        idx = '0;
        if (int'(addr_hi) == PAGE_BASE) begin
            hit = 1'b1;
            idx = IW'(2 * int'(addr_lo));
        end else if (int'(addr_hi) == PAGE_BASE + 1) begin
            hit = 1'b1;
            idx = IW'(2 * int'(addr_lo) + 1);
        end else if (int'(addr_hi) >= PAGE_BASE + 2 &&
                     int'(addr_hi) <  PAGE_BASE + 2 + EXTRA &&
                     addr_lo == '0) begin
            hit = 1'b1;
            idx = IW'(PAIR_SEGS + int'(addr_hi) - PAGE_BASE - 2);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) mem[i] <= '0;
        end else if (wr_en && hit) begin
            mem[idx] <= wr_data;
        end
    end

    assign rd_data = hit ? mem[idx] : '0;

    for (genvar g = 0; g < NSEG; g++) begin : g_flat
        assign words_flat[g*DW +: DW] = mem[g];
    end

    assert_unmapped_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(words_flat));

    assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) |=> (words_flat[$past(idx)*DW +: DW] == $past(wr_data)));

endmodule

// File: rtl/lcd_scan_fsm.sv
module lcd_scan_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    output logic [1:0] act_com,
    output logic       neg_half
);
    typedef enum logic [2:0] {
        S_H0_POS, S_H0_NEG, S_H1_POS, S_H1_NEG,
        S_H2_POS, S_H2_NEG, S_H3_POS, S_H3_NEG
    } scan_e;

    scan_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (tick) begin
            unique case (state)
                S_H0_POS: state_nx = S_H0_NEG;
                S_H0_NEG: state_nx = S_H1_POS;
                S_H1_POS: state_nx = S_H1_NEG;
                S_H1_NEG: state_nx = S_H2_POS;
                S_H2_POS: state_nx = S_H2_NEG;
                S_H2_NEG: state_nx = S_H3_POS;
                S_H3_POS: state_nx = S_H3_NEG;
                S_H3_NEG: state_nx = S_H0_POS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_H0_POS;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            S_H0_POS: begin act_com = 2'd0; neg_half = 1'b0; end
            S_H0_NEG: begin act_com = 2'd0; neg_half = 1'b1; end
            S_H1_POS: begin act_com = 2'd1; neg_half = 1'b0; end
            S_H1_NEG: begin act_com = 2'd1; neg_half = 1'b1; end
            S_H2_POS: begin act_com = 2'd2; neg_half = 1'b0; end
            S_H2_NEG: begin act_com = 2'd2; neg_half = 1'b1; end
            S_H3_POS: begin act_com = 2'd3; neg_half = 1'b0; end
            S_H3_NEG: begin act_com = 2'd3; neg_half = 1'b1; end
        endcase
    end

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state));

    assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == S_H3_NEG) |=> (state == S_H0_POS));

    assert_polarity_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (neg_half != $past(neg_half)));

endmodule

// File: rtl/lcd_level_gen.sv
module lcd_level_gen
    import lcd_pkg::*;
#(
    parameter int NSEG = 34
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        blank,
    input  logic [1:0]                  act_com,
    input  logic                        neg_half,
    input  logic [NSEG*LCD_NCOM-1:0]    words_flat,
    output logic [2*LCD_NCOM-1:0]       com_lvl,
    output logic [2*NSEG-1:0]           seg_lvl
);
    lvl_e act_lvl;
    logic [LCD_NCOM-1:0] com_not_half;
    logic [NSEG-1:0]     seg_is_half;

    assign act_lvl = neg_half ? LVL_GND : LVL_FULL;

    for (genvar c = 0; c < LCD_NCOM; c++) begin : g_com
        always_comb begin
            if (blank)                 com_lvl[2*c +: 2] = LVL_HALF;
            else if (int'(act_com) == c) com_lvl[2*c +: 2] = act_lvl;
            else                       com_lvl[2*c +: 2] = LVL_HALF;
        end
        assign com_not_half[c] = (com_lvl[2*c +: 2] != LVL_HALF);
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic on_bit;
        assign on_bit = words_flat[s*LCD_NCOM + int'(act_com)];
        always_comb begin
            if (blank)       seg_lvl[2*s +: 2] = LVL_HALF;
            else if (on_bit) seg_lvl[2*s +: 2] = lvl_mirror(act_lvl);
            else             seg_lvl[2*s +: 2] = act_lvl;
        end
        assign seg_is_half[s] = (seg_lvl[2*s +: 2] == LVL_HALF);
    end

    assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |-> ($countones(com_not_half) == 1));

    assert_seg_full_swing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !blank |-> (seg_is_half == '0));

    assert_blank_all_half_R11: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (com_not_half == '0 && seg_is_half == '1));

endmodule

// File: rtl/lcd_mux_drv.sv
module lcd_mux_drv
    import lcd_pkg::*;
#(
    parameter int NSEG      = 34,
    parameter int AW        = 4,
    parameter int PAGE_BASE = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     blank,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr_hi,
    input  logic [AW-1:0]            addr_lo,
    input  logic [LCD_NCOM-1:0]      wr_data,
    output logic [LCD_NCOM-1:0]      rd_data,
    output logic [2*LCD_NCOM-1:0]    com_lvl,
    output logic [2*NSEG-1:0]        seg_lvl
);
    logic [NSEG*LCD_NCOM-1:0] words_flat;
    logic [1:0]               act_com;
    logic                     neg_half;

    lcd_disp_mem #(
        .NSEG(NSEG), .DW(LCD_NCOM), .AW(AW), .PAGE_BASE(PAGE_BASE)
    ) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr_hi(addr_hi), .addr_lo(addr_lo), .wr_data(wr_data),
        .rd_data(rd_data), .words_flat(words_flat)
    );

    lcd_scan_fsm u_scan (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .act_com(act_com), .neg_half(neg_half)
    );

    lcd_level_gen #(.NSEG(NSEG)) u_lvl (
        .clk(clk), .rst_n(rst_n), .blank(blank),
        .act_com(act_com), .neg_half(neg_half), .words_flat(words_flat),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

endmodule

// File: tb/lcd_mux_drv_tb.sv
module lcd_mux_drv_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSEG = 34;

    logic        clk = 1'b0;
    logic        rst_n, tick, blank, wr_en;
    logic [3:0]  addr_hi, addr_lo, wr_data, rd_data;
    logic [7:0]  com_lvl;
    logic [67:0] seg_lvl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int ph = 0;
    logic [3:0] mem_m [NSEG];

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_mux_drv u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .blank(blank), .wr_en(wr_en),
        .addr_hi(addr_hi), .addr_lo(addr_lo), .wr_data(wr_data),
        .rd_data(rd_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    function automatic int map_addr(logic [3:0] hi, logic [3:0] lo);
        if (hi == 4'd8)  return 2 * int'(lo);
        if (hi == 4'd9)  return 2 * int'(lo) + 1;
        if (hi == 4'd10 && lo == 4'd0) return 32;
        if (hi == 4'd11 && lo == 4'd0) return 33;
        return -1;
    endfunction

    function automatic logic [7:0] exp_com(int p, logic bl);
        logic [7:0] v;
        for (int i = 0; i < 4; i++) begin
            if (bl)             v[2*i +: 2] = 2'd1;
            else if (i == p/2)  v[2*i +: 2] = (p % 2 == 1) ? 2'd0 : 2'd2;
            else                v[2*i +: 2] = 2'd1;
        end
        return v;
    endfunction

    function automatic logic [67:0] exp_seg(int p, logic bl);
        logic [67:0] v;
        logic [1:0] a;
        a = (p % 2 == 1) ? 2'd0 : 2'd2;
        for (int j = 0; j < NSEG; j++) begin
            if (bl)                  v[2*j +: 2] = 2'd1;
            else if (mem_m[j][p/2])  v[2*j +: 2] = 2'd2 - a;
            else                     v[2*j +: 2] = a;
        end
        return v;
    endfunction

    task automatic chk_out(string req);
        checks++;
        if (com_lvl !== exp_com(ph, blank) || seg_lvl !== exp_seg(ph, blank)) begin
            errors++;
            $display("FAIL %s com=%h seg=%h expected com=%h seg=%h", req,
                     com_lvl, seg_lvl, exp_com(ph, blank), exp_seg(ph, blank));
        end
    endtask

    task automatic chk_rd(string req);
        int k;
        logic [3:0] e;
        k = map_addr(addr_hi, addr_lo);
        e = (k < 0) ? 4'd0 : mem_m[k];
        checks++;
        if (rd_data !== e) begin
            errors++;
            $display("FAIL %s rd_data=%h expected %h (addr %h:%h)", req, rd_data, e, addr_hi, addr_lo);
        end
    endtask

    // drive after a falling edge, let one rising edge pass, return at the next falling edge
    task automatic cyc(logic we, logic [3:0] hi, logic [3:0] lo, logic [3:0] d, logic tk, logic bl);
        int k;
        wr_en = we; addr_hi = hi; addr_lo = lo; wr_data = d; tick = tk; blank = bl;
        @(posedge clk);
        k = map_addr(hi, lo);
        if (we && k >= 0) mem_m[k] = d;
        if (tk) ph = (ph + 1) % 8;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s;
        s = $urandom(32'h5eed_1c4d);
        for (int i = 0; i < NSEG; i++) mem_m[i] = 4'd0;
        rst_n = 1'b0; tick = 1'b0; blank = 1'b0; wr_en = 1'b0;
        addr_hi = 4'd0; addr_lo = 4'd0; wr_data = 4'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1 reset state");

        // R5: even page
        cyc(1'b1, 4'd8, 4'd3, 4'b0001, 1'b0, 1'b0);
        chk_out("R5 page8 word3 -> seg6");
        chk_rd("R10 readback page8");
        // R6: odd page, bit 3 only shows in H3 phases
        cyc(1'b1, 4'd9, 4'd15, 4'b1000, 1'b0, 1'b0);
        chk_out("R6 page9 word15 -> seg31");
        // R7: one-word pages
        cyc(1'b1, 4'd10, 4'd0, 4'b0101, 1'b0, 1'b0);
        chk_out("R7 page10 -> seg32");
        cyc(1'b1, 4'd11, 4'd0, 4'b1010, 1'b0, 1'b0);
        chk_out("R7 page11 -> seg33");
        chk_rd("R10 readback page11");

        // R9: unmapped writes
        cyc(1'b1, 4'd10, 4'd5, 4'hF, 1'b0, 1'b0);
        chk_out("R9 unmapped page10 word5");
        chk_rd("R9 unmapped read");
        cyc(1'b1, 4'd3, 4'd0, 4'hF, 1'b0, 1'b0);
        cyc(1'b1, 4'd12, 4'd0, 4'hF, 1'b0, 1'b0);
        chk_out("R9 unmapped pages 3 and 12");
        chk_rd("R9 unmapped page12 read");

        // R2, R3, R4, R8: walk two full frames, one clock idle between ticks
        for (int t = 0; t < 16; t++) begin
            cyc(1'b0, 4'd8, 4'd3, 4'd0, 1'b1, 1'b0);
            chk_out("R2 R3 R4 R8 scan step");
            cyc(1'b0, 4'd9, 4'd15, 4'd0, 1'b0, 1'b0);
            chk_out("R2 hold without tick");
        end

        // R11: blank, with the scan advancing underneath
        cyc(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b1);
        chk_out("R11 blank all half");
        cyc(1'b0, 4'd0, 4'd0, 4'd0, 1'b1, 1'b1);
        cyc(1'b0, 4'd0, 4'd0, 4'd0, 1'b1, 1'b1);
        chk_out("R11 blank during ticks");
        cyc(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0);
        chk_out("R11 R2 scan position kept across blank");

        // R10: write while scanning, same-cycle readback
        cyc(1'b1, 4'd9, 4'd0, 4'b0110, 1'b1, 1'b0);
        chk_rd("R10 readback during tick");
        chk_out("R6 R8 write during tick");

        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            logic [3:0] hi;
            logic [3:0] lo;
            hi = (($urandom % 8) < 6) ? 4'(8 + ($urandom % 4)) : 4'($urandom);
            lo = (($urandom % 4) == 0) ? 4'd0 : 4'($urandom);
            cyc(1'($urandom % 2), hi, lo, 4'($urandom), 1'(($urandom % 3) == 0),
                1'(($urandom % 10) == 0));
            chk_out("R3 R4 R5 R6 R7 R8 random");
            chk_rd("R9 R10 random read");
        end

        // reset mid-frame returns to the reset picture
        cyc(1'b0, 4'd0, 4'd0, 4'd0, 1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ph = 0;
        for (int i = 0; i < NSEG; i++) mem_m[i] = 4'd0;
        @(negedge clk);
        chk_out("R1 reset after traffic");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule